// File: doc/BRIEF.md
# Sequential Nonrestoring Modulo Reducer

This block computes `z = x mod m` for an N-bit unsigned operand `x` and a K-bit modulus `m` (K ≤ N). It uses one add-or-subtract step per clock. A one-cycle `start` pulse, sampled while the block is idle, captures both operands. The partial remainder sits in an (N+2)-bit two's-complement register.

Each iteration looks only at the sign bit of that register. If the remainder is non-negative, the aligned modulus is subtracted; if it is negative, the modulus is added. The register is then shifted left one place, except after the final iteration, so the modulus never has to move. The aligned modulus has N−K zero low bits, so only the top K+2 bits of the register pass through the adder. After N−K+1 iterations the remainder lies in [−m, m). One correction cycle adds `m` back when it is negative, and then a one-cycle `done` pulse marks the result as valid.

The modulus must be normalized: bit K−1 of `m` must be set. Any other modulus, including zero, gives an undefined result. In the K=1 configuration this leaves `m = 1`.

Top module: `nr_reducer`

## Requirements
- R1: After reset, `done` and `busy` are 0 and `z` is 0.
- R2: A `start` pulse sampled while `busy` is 0 captures `xIn` and `mIn`. From the next cycle, `busy` is 1 and `done` is 0.
- R3: For every `xIn` in [0, 2^N) and every `mIn` with bit K−1 set, the reported `z` equals `xIn mod mIn`.
- R4: `done` is first seen high N−K+3 cycles after the cycle in which `start` is sampled, counting the cycle of that clock edge as the first.
- R5: `done` stays high for exactly one cycle, and only while `busy` is 1. `busy` is 0 in the cycle after `done`.
- R6: While `busy` is 1, including the `done` cycle, `start`, `xIn` and `mIn` have no effect: the result in progress is unchanged and `busy` falls after `done` as usual.
- R7: `z` changes only in a cycle where `done` is 1. It then holds its value, whatever `xIn` and `mIn` do, until the next result.
- R8: Corner cases are exact. `xIn < mIn` returns `xIn`. Any multiple of `mIn` (including 0) returns 0. `xIn = 2^N−1` returns its true residue. With K=1 and `m = 1`, the result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a reduction (sampled only when idle) |
| xIn | input | N | Operand to reduce |
| mIn | input | K | Modulus, bit K−1 set |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: `z` is valid |
| z | output | K | Residue `xIn mod mIn` |

## Verification
A wrong add/subtract choice or a lost shift leaves the remainder off by a multiple of a power-of-two scaled modulus. This shows up as a wrong `z` in the same `done` pulse, N−K+3 cycles after `start`. A stuck or miscounted iteration counter moves the `done` pulse off its fixed slot, so the latency check and the cycle counter in the checker catch it on the first operation. A full sweep of every `x` against every legal `m` in the small configuration covers both the negative and non-negative correction paths, including the zero-remainder boundary.

// File: rtl/nrr_pkg.sv
package nrr_pkg;
  typedef struct packed {
    logic load;     // capture operands into datapath
    logic step;     // one nonrestoring add/subtract
    logic shiftEn;  // double the remainder after the step
    logic correct;  // final sign correction, write result
  } nrrCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ITERATE = 2'd1,
    ST_CORRECT = 2'd2,
    ST_DONE    = 2'd3
  } nrrState_t;
endpackage

// File: rtl/nrr_ctrl.sv
module nrr_ctrl
  import nrr_pkg::*;
#(
  parameter int N = 8,
  parameter int K = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output nrrCtrl_t ctrl,
  output logic     busy,
  output logic     done
);
  localparam int ITERS = N - K + 1;
  localparam int CW    = $clog2(ITERS + 1);

  nrrState_t      state, stateNext;
  logic [CW-1:0]  iterCnt, iterCntNext;
  logic           lastIter;

  assign lastIter = (iterCnt == CW'(1));

  always_comb begin
    stateNext    = state;
    iterCntNext  = iterCnt;
    ctrl         = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctrl.load   = 1'b1;
          iterCntNext = CW'(ITERS);
          stateNext   = ST_ITERATE;
        end
      end
      ST_ITERATE: begin
        ctrl.step    = 1'b1;
        ctrl.shiftEn = !lastIter;
        iterCntNext  = iterCnt - CW'(1);
        if (lastIter) stateNext = ST_CORRECT;
      end
      ST_CORRECT: begin
        ctrl.correct = 1'b1;
        stateNext    = ST_DONE;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
    end else begin
      state   <= stateNext;
      iterCnt <= iterCntNext;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/nrr_datapath.sv
module nrr_datapath
  import nrr_pkg::*;
#(
  parameter int N = 8,
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  nrrCtrl_t     ctrl,
  input  logic [N-1:0] xIn,
  input  logic [K-1:0] mIn,
  output logic [K-1:0] z
);
  localparam int W  = N + 2;   // partial remainder width
  localparam int SH = N - K;   // zero low bits of aligned modulus
  localparam int H  = K + 2;   // adder slice width incl. sign

  logic [W-1:0] sReg;
  logic [K-1:0] mReg;
  logic [K-1:0] zReg;

  logic [H-1:0] hiSlice, mExt, stepSum, corrSum;
  logic [W-1:0] stepFull, stepNext;
  logic         isNeg;

  assign hiSlice = sReg[W-1:SH];
  assign mExt    = {2'b00, mReg};
  assign isNeg   = sReg[W-1];

  // sign picks the operation: negative -> add, otherwise subtract
  assign stepSum = isNeg ? (hiSlice + mExt) : (hiSlice - mExt);
  assign corrSum = isNeg ? (hiSlice + mExt) : hiSlice;

  generate
    if (SH > 0) begin : g_lowPass
      assign stepFull = {stepSum, sReg[SH-1:0]};
    end else begin : g_noLow
      assign stepFull = stepSum;
    end
  endgenerate

  assign stepNext = ctrl.shiftEn ? {stepFull[W-2:0], 1'b0} : stepFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sReg <= '0;
      mReg <= '0;
      zReg <= '0;
    end else begin
      if (ctrl.load) begin
        sReg <= {2'b00, xIn};
        mReg <= mIn;
      end else if (ctrl.step) begin
        sReg <= stepNext;
      end
      if (ctrl.correct) zReg <= corrSum[K-1:0];
    end
  end

  assign z = zReg;
endmodule

// File: rtl/nr_reducer.sv
module nr_reducer
  import nrr_pkg::*;
#(
  parameter int N = 8,
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [N-1:0] xIn,
  input  logic [K-1:0] mIn,
  output logic         busy,
  output logic         done,
  output logic [K-1:0] z
);
  nrrCtrl_t ctrl;

  nrr_ctrl #(.N(N), .K(K)) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctrl  (ctrl),
    .busy  (busy),
    .done  (done)
  );

  nrr_datapath #(.N(N), .K(K)) dp_i (
    .clk  (clk),
    .rstN (rstN),
    .ctrl (ctrl),
    .xIn  (xIn),
    .mIn  (mIn),
    .z    (z)
  );
endmodule

// File: rtl/nrr_checker.sv
module nrr_checker #(
  parameter int N = 8,
  parameter int K = 4
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [K-1:0] z
);
  localparam int LAT = N - K + 3;
  localparam int LW  = $clog2(LAT + 2);

  logic [LW-1:0] latCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latCnt <= '0;
    else if (start && !busy) latCnt <= LW'(1);
    else if (busy && latCnt != {LW{1'b1}}) latCnt <= latCnt + LW'(1);
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !done));

  // R4
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (latCnt == LW'(LAT)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R5
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R7
  z_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(z) |-> done);
endmodule

bind nr_reducer nrr_checker #(.N(N), .K(K)) chk_i (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done),
  .z     (z)
);

// File: tb/nr_reducer_tb_top.sv
module nr_reducer_tb_top;
  localparam int N  = 8;
  localparam int K  = 4;
  localparam int NB = 5;
  localparam int KB = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic          start, busy, done;
  logic [N-1:0]  xIn;
  logic [K-1:0]  mIn, z;

  logic          startB, busyB, doneB;
  logic [NB-1:0] xInB;
  logic [KB-1:0] mInB, zB;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  nr_reducer #(.N(N), .K(K)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .xIn(xIn), .mIn(mIn),
    .busy(busy), .done(done), .z(z)
  );

  nr_reducer #(.N(NB), .K(KB)) dutB_i (
    .clk(clk), .rstN(rstN), .start(startB), .xIn(xInB), .mIn(mInB),
    .busy(busyB), .done(doneB), .z(zB)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  // run one operation on the main instance, return result and latency
  task automatic runOp(input int x, input int m, output int res, output int lat);
    @(negedge clk);
    xIn = N'(x); mIn = K'(m); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    res = int'(z);
  endtask

  initial begin
    int res, lat;
    start = 0; xIn = '0; mIn = '0;
    startB = 0; xInB = '0; mInB = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!done && !busy && z == '0, "R1", int'({busy, done}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !busy && z == '0, "R1", int'(z), 0);

    // R2 acceptance
    @(negedge clk);
    xIn = 8'd100; mIn = 4'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !done, "R2", int'({busy, done}), 2);
    while (!done) @(negedge clk);
    check(int'(z) == 100 % 9, "R2", int'(z), 100 % 9);
    @(negedge clk);

    // R3 / R4 exhaustive sweep over legal moduli
    for (int m = 8; m < 16; m++) begin
      for (int x = 0; x < 256; x++) begin
        runOp(x, m, res, lat);
        check(res == x % m, "R3", res, x % m);
        check(lat == N - K + 3, "R4", lat, N - K + 3);
        // R5 one-cycle pulse then idle
        @(negedge clk);
        check(!done && !busy, "R5", int'({busy, done}), 0);
      end
    end

    // R8 corners
    runOp(5, 12, res, lat);   check(res == 5, "R8", res, 5);
    runOp(13, 13, res, lat);  check(res == 0, "R8", res, 0);
    runOp(0, 15, res, lat);   check(res == 0, "R8", res, 0);
    runOp(255, 8, res, lat);  check(res == 255 % 8, "R8", res, 255 % 8);
    runOp(255, 15, res, lat); check(res == 0, "R8", res, 0);
    runOp(255, 11, res, lat); check(res == 255 % 11, "R8", res, 255 % 11);

    // R7 hold while inputs wander
    runOp(200, 13, res, lat);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      xIn = N'(i * 37); mIn = K'(8 + i);
      check(int'(z) == 200 % 13 && !done, "R7", int'(z), 200 % 13);
    end

    // R6 start and operand changes ignored while busy
    @(negedge clk);
    xIn = 8'd250; mIn = 4'd14; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    xIn = 8'd7; mIn = 4'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0; xIn = 8'd1; mIn = 4'd15;
    while (!done) @(negedge clk);
    check(int'(z) == 250 % 14, "R6", int'(z), 250 % 14);
    start = 1'b1; xIn = 8'd99;      // during done cycle
    @(negedge clk);
    start = 1'b0;
    check(!busy && !done, "R6", int'({busy, done}), 0);
    check(int'(z) == 250 % 14, "R6", int'(z), 250 % 14);

    // R8 single-bit modulus configuration
    for (int x = 0; x < 32; x++) begin
      int latB;
      @(negedge clk);
      xInB = NB'(x); mInB = 1'b1; startB = 1'b1;
      @(negedge clk);
      startB = 1'b0;
      latB = 1;
      while (!doneB && latB < 60) begin
        @(negedge clk);
        latB++;
      end
      check(zB == 1'b0 && doneB, "R8", int'(zB), 0);
      check(latB == NB - KB + 3, "R4", latB, NB - KB + 3);
    end

    finishRun();
  end
endmodule